// File: doc/BRIEF.md
# Software Interrupt Pending Controller

This block lets any hart post an inter-processor interrupt to another hart through a memory-mapped register file. Each hart owns exactly one interrupt source, whose ID is the hart number plus one. Software sets that source's pending flag with a write. The target hart sees its interrupt line rise only when three things hold for the source: it is enabled in that hart's enable array, it has a nonzero priority, and it is not already in service. ID 0 exists in the numbering but can never become pending.

The target hart takes the interrupt by reading its claim register. The read returns the winning ID, clears that ID's pending flag and marks it in service. When the handler is done, the hart writes the same ID back to the claim register to finish it. With the default 32 harts there are 33 IDs, so the pending array and each enable array take two 32-bit words. The ID of hart 31 is bit 0 of the second word.

The register bus is a simple single-cycle request port. A read returns its data one cycle after the request.

Top module: `ipi_pend_ctrl`

## Requirements
- R1: After reset every `irq_o` line is low and every register reads zero, including a claim read.
- R2: Hart h owns ID h+1. The flag for an ID sits in bit (ID mod 32) of the pending word at byte offset 0x1000 + 4·(ID div 32). Bit 0 of the word at 0x1000 (ID 0) always reads 0 and cannot be set.
- R3: A write to a pending word sets each flag whose data bit is 1. Data bits that are 0 leave the existing flags unchanged.
- R4: The enable array of hart h starts at byte offset 0x2000 + h·0x80 and uses the same word and bit indexing as the pending array. It can be read and written. The ID 0 bit always reads 0.
- R5: The priority of ID n (1 ≤ n ≤ harts) is a 3-bit value at byte offset 4·n and reads back as written, zero-extended. Bits above bit 2 are dropped.
- R6: `irq_o[h]` is high exactly when some ID is pending, enabled for hart h, has nonzero priority and is not in service.
- R7: A read of the claim register of hart h, at byte offset 0x200004 + h·0x1000, returns the qualifying ID (as defined in R6) with the highest priority. On equal priority the lowest ID wins. The read clears that ID's pending flag and marks the ID in service. If no ID qualifies, the read returns 0 and changes nothing.
- R8: Writing an ID to hart h's claim register ends its in-service state if that ID is enabled for hart h. A write naming an ID that is not enabled for h, or naming ID 0, or naming an ID out of range, is ignored.
- R9: Read data appears on `rdata_o`, with `rvalid_o` high, in the cycle after the read request.
- R10: A read of an unmapped offset returns 0, and a write to an unmapped offset changes no state. Unmapped offsets include priority offset 0, pending or enable words beyond the ID range, and any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request valid this cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 22 | Byte address; bits 1:0 are ignored |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |
| irq_o | output | 32 | Interrupt line for each hart |

## Verification
The assertions check three things on every cycle. First, a pending flag rises only after a write, and it falls only after a read, at most one flag at a time. Second, an in-service mark is set only by a read and cleared only by a write. Third, an interrupt line is never high without a pending source that is out of service, and read data is valid exactly one cycle after a read request. Other properties need whole scenarios, so only the bench can show them. These are the address-to-bit mapping of the second word used by hart 31, the choice between priority and lowest ID in a claim, the masking of a re-raised interrupt while its ID is still in service, and the rejection of a completion from a hart that does not enable the ID.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_PEND,
    RK_EN,
    RK_CLAIM
  } rkind_e;

  typedef struct packed {
    rkind_e      kind;
    logic [4:0]  hart;
    logic [4:0]  word;
    logic [9:0]  idx;
  } rdec_t;
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec
  import ipi_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int NUM_HARTS = 32,
  parameter int NUM_WORDS = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rdec_t             dec_o
);
  localparam int PAGE_W     = ADDR_W - 12;
  localparam int CLAIM_PAGE = 'h200;

  logic [PAGE_W-1:0] page;
  logic              unused_lsb;

  assign page       = addr_i[ADDR_W-1:12];
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    dec_o      = '0;
    dec_o.kind = RK_NONE;
    if (int'(page) == 0) begin
      if (int'(addr_i[11:2]) >= 1 && int'(addr_i[11:2]) <= NUM_HARTS) begin
        dec_o.kind = RK_PRIO;
        dec_o.idx  = addr_i[11:2];
      end
    end else if (int'(page) == 1) begin
      if (int'(addr_i[11:2]) < NUM_WORDS) begin
        dec_o.kind = RK_PEND;
        dec_o.word = addr_i[6:2];
      end
    end else if (int'(page) == 2) begin
      if (int'(addr_i[11:7]) < NUM_HARTS && int'(addr_i[6:2]) < NUM_WORDS) begin
        dec_o.kind = RK_EN;
        dec_o.hart = addr_i[11:7];
        dec_o.word = addr_i[6:2];
      end
    end else if (int'(page) >= CLAIM_PAGE && int'(page) < CLAIM_PAGE + NUM_HARTS
                 && addr_i[11:0] == 12'h004) begin
      dec_o.kind = RK_CLAIM;
      dec_o.hart = 5'(int'(page) - CLAIM_PAGE);
    end
  end
endmodule

// File: rtl/ipi_prio_pick.sv
module ipi_prio_pick #(
  parameter int NUM_IDS = 33,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic [NUM_IDS-1:0]             cand_i,
  input  logic [NUM_IDS-1:0][PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]                id_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lowest ID on equal priority
  always_comb begin
    id_o = '0;
    best = '0;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (cand_i[i] && (id_o == '0 || prio_i[i] > best)) begin
        id_o = ID_W'(i);
        best = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/ipi_hart_gate.sv
module ipi_hart_gate #(
  parameter int NUM_IDS = 33
) (
  input  logic [NUM_IDS-1:0] live_i,
  input  logic [NUM_IDS-1:0] en_i,
  output logic               irq_o
);
  assign irq_o = |(live_i & en_i);
endmodule

// File: rtl/ipi_pend_ctrl.sv
module ipi_pend_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_HARTS = 32,
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic                 rvalid_o,
  output logic [31:0]          rdata_o,
  output logic [NUM_HARTS-1:0] irq_o
);
  localparam int NUM_IDS   = NUM_HARTS + 1;
  localparam int NUM_WORDS = (NUM_IDS + 31) / 32;
  localparam int ID_W      = $clog2(NUM_IDS);
  localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int PAD_W     = NUM_WORDS * 32;

  rdec_t dec;

  logic [NUM_IDS-1:0]                    pend_q, pend_d;
  logic [NUM_IDS-1:0]                    isv_q, isv_d;
  logic [NUM_HARTS-1:0][NUM_IDS-1:0]     en_q, en_d;
  logic [NUM_IDS-1:0][PRIO_W-1:0]        prio_q, prio_d;
  logic [NUM_IDS-1:0]                    prio_nz, live, cand;
  logic [HART_W-1:0]                     sel_h;
  logic [WORD_W-1:0]                     sel_w;
  logic [ID_W-1:0]                       pick_id;
  logic [PAD_W-1:0]                      pend_pad, en_pad;
  logic                                  wr, rd;
  logic [31:0]                           rdata_d;
  logic                                  rvalid_q;
  logic [31:0]                           rdata_q;

  ipi_addr_dec #(
    .ADDR_W   (ADDR_W),
    .NUM_HARTS(NUM_HARTS),
    .NUM_WORDS(NUM_WORDS)
  ) u_dec (
    .addr_i(addr_i),
    .dec_o (dec)
  );

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign sel_h = dec.hart[HART_W-1:0];
  assign sel_w = dec.word[WORD_W-1:0];

  always_comb begin
    for (int i = 0; i < NUM_IDS; i++) prio_nz[i] = |prio_q[i];
  end

  assign live = pend_q & prio_nz & ~isv_q;
  assign cand = live & en_q[sel_h];

  ipi_prio_pick #(
    .NUM_IDS(NUM_IDS),
    .PRIO_W (PRIO_W),
    .ID_W   (ID_W)
  ) u_pick (
    .cand_i(cand),
    .prio_i(prio_q),
    .id_o  (pick_id)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    ipi_hart_gate #(.NUM_IDS(NUM_IDS)) u_gate (
      .live_i(live),
      .en_i  (en_q[h]),
      .irq_o (irq_o[h])
    );
  end

  assign pend_pad = PAD_W'(pend_q);
  assign en_pad   = PAD_W'(en_q[sel_h]);

  always_comb begin
    unique case (dec.kind)
      RK_PRIO:  rdata_d = 32'(prio_q[dec.idx[ID_W-1:0]]);
      RK_PEND:  rdata_d = pend_pad[32*int'(sel_w) +: 32];
      RK_EN:    rdata_d = en_pad[32*int'(sel_w) +: 32];
      RK_CLAIM: rdata_d = 32'(pick_id);
      default:  rdata_d = '0;
    endcase
  end

  // ID 0 is never updated, so it stays at its reset value of zero
  always_comb begin
    pend_d = pend_q;
    isv_d  = isv_q;
    en_d   = en_q;
    prio_d = prio_q;
    for (int i = 1; i < NUM_IDS; i++) begin
      if (wr && dec.kind == RK_PEND && int'(sel_w) == i / 32 && wdata_i[i % 32])
        pend_d[i] = 1'b1;
      if (wr && dec.kind == RK_EN && int'(sel_w) == i / 32)
        en_d[sel_h][i] = wdata_i[i % 32];
      if (wr && dec.kind == RK_PRIO && int'(dec.idx) == i)
        prio_d[i] = wdata_i[PRIO_W-1:0];
      if (rd && dec.kind == RK_CLAIM && int'(pick_id) == i) begin
        pend_d[i] = 1'b0;
        isv_d[i]  = 1'b1;
      end
      if (wr && dec.kind == RK_CLAIM && wdata_i == 32'(i) && en_q[sel_h][i])
        isv_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      isv_q    <= '0;
      en_q     <= '0;
      prio_q   <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      pend_q   <= pend_d;
      isv_q    <= isv_d;
      en_q     <= en_d;
      prio_q   <= prio_d;
      rvalid_q <= rd;
      rdata_q  <= rd ? rdata_d : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/ipi_pend_ctrl_chk.sv
module ipi_pend_ctrl_chk #(
  parameter int NUM_HARTS = 32,
  parameter int NUM_IDS   = 33
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic                 rvalid_o,
  input logic [NUM_HARTS-1:0] irq_o,
  input logic [NUM_IDS-1:0]   pend_q,
  input logic [NUM_IDS-1:0]   isv_q
);
  AST_PEND_SET_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(pend_q & ~$past(pend_q)) |-> $past(req_i && we_i)); // R3

  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |irq_o |-> |(pend_q & ~isv_q)); // R6

  AST_PEND_CLEAR_BY_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |($past(pend_q) & ~pend_q) |-> $past(req_i && !we_i)); // R7

  AST_ONE_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones($past(pend_q) & ~pend_q) <= 1); // R7

  AST_ISV_SET_BY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(isv_q & ~$past(isv_q)) |-> $past(req_i && !we_i)); // R7

  AST_ISV_CLEAR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |($past(isv_q) & ~isv_q) |-> $past(req_i && we_i)); // R8

  AST_READ_GIVES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R9

  AST_VALID_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i)); // R9
endmodule

bind ipi_pend_ctrl ipi_pend_ctrl_chk #(
  .NUM_HARTS(NUM_HARTS),
  .NUM_IDS  (NUM_IDS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .rvalid_o(rvalid_o),
  .irq_o   (irq_o),
  .pend_q  (pend_q),
  .isv_q   (isv_q)
);

// File: tb/test_ipi_pend_ctrl.sv
module test_ipi_pend_ctrl;
  localparam int NH = 32;
  localparam int NI = NH + 1;
  localparam int PW = 3;
  localparam int AW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          rvalid;
  logic [31:0]   rdata;
  logic [NH-1:0] irq;

  int n_tests = 0;
  int n_fail  = 0;

  logic [NI-1:0] m_pend;
  logic [NI-1:0] m_isv;
  logic [NI-1:0] m_en [NH];
  logic [PW-1:0] m_prio [NI];

  always #10 clk = ~clk;

  ipi_pend_ctrl i_ipi_pend_ctrl (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rvalid_o(rvalid),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  function automatic int m_best(int h);
    int b = 0;
    int bp = 0;
    for (int id = 1; id < NI; id++) begin
      if (m_pend[id] && m_en[h][id] && m_prio[id] != 0 && !m_isv[id] &&
          (b == 0 || int'(m_prio[id]) > bp)) begin
        b  = id;
        bp = int'(m_prio[id]);
      end
    end
    return b;
  endfunction

  function automatic logic [NH-1:0] m_irq();
    logic [NH-1:0] v;
    for (int h = 0; h < NH; h++) v[h] = (m_best(h) != 0);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic m_write(int a, logic [31:0] d);
    int page = a >> 12;
    int off  = a & 'hfff;
    if (page == 0) begin
      if (off / 4 >= 1 && off / 4 <= NH) m_prio[off / 4] = d[PW-1:0];
    end else if (page == 1) begin
      if (off / 4 < 2)
        for (int b = 0; b < 32; b++) begin
          int id = (off / 4) * 32 + b;
          if (id >= 1 && id < NI && d[b]) m_pend[id] = 1'b1;
        end
    end else if (page == 2) begin
      int h = off / 128;
      int w = (off % 128) / 4;
      if (h < NH && w < 2)
        for (int b = 0; b < 32; b++) begin
          int id = w * 32 + b;
          if (id >= 1 && id < NI) m_en[h][id] = d[b];
        end
    end else if (page >= 'h200 && page < 'h200 + NH && off == 4) begin
      if (d >= 1 && d < NI && m_en[page - 'h200][d]) m_isv[d] = 1'b0;
    end
  endtask

  task automatic m_read(int a, output logic [31:0] r);
    int page = a >> 12;
    int off  = a & 'hfff;
    r = '0;
    if (page == 0) begin
      if (off / 4 >= 1 && off / 4 <= NH) r = 32'(m_prio[off / 4]);
    end else if (page == 1) begin
      if (off / 4 < 2)
        for (int b = 0; b < 32; b++) begin
          int id = (off / 4) * 32 + b;
          if (id < NI) r[b] = m_pend[id];
        end
    end else if (page == 2) begin
      int h = off / 128;
      int w = (off % 128) / 4;
      if (h < NH && w < 2)
        for (int b = 0; b < 32; b++) begin
          int id = w * 32 + b;
          if (id >= 1 && id < NI) r[b] = m_en[h][id];
        end
    end else if (page >= 'h200 && page < 'h200 + NH && off == 4) begin
      int id = m_best(page - 'h200);
      r = 32'(id);
      if (id != 0) begin
        m_pend[id] = 1'b0;
        m_isv[id]  = 1'b1;
      end
    end
  endtask

  task automatic bus_wr(int a, logic [31:0] d, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    m_write(a, d);
    chk({tag, " R6 irq"}, 32'(irq), 32'(m_irq()));
  endtask

  task automatic bus_rd(int a, string tag);
    logic [31:0] e;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    m_read(a, e);
    chk({tag, " R9 rvalid"}, 32'(rvalid), 32'd1);
    chk(tag, rdata, e);
    chk({tag, " R6 irq"}, 32'(irq), 32'(m_irq()));
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_pend = '0;
    m_isv  = '0;
    for (int h = 0; h < NH; h++) m_en[h] = '0;
    for (int i = 0; i < NI; i++) m_prio[i] = '0;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    chk("R9 no rvalid idle", 32'(rvalid), 32'd0);
    bus_rd('h1000, "R1 pend0");
    bus_rd('h1004, "R1 pend1");
    bus_rd('h0004, "R1 prio1");
    bus_rd('h2F84, "R1 en31");
    bus_rd('h200004, "R1 claim0");

    // R5 priority read-back and truncation, ID 0 slot unmapped
    bus_wr('h0004, 32'hFFFF_FFFF, "R5 prio wr");
    bus_rd('h0004, "R5 prio rd");
    bus_wr('h0000, 32'h5, "R10 prio0 wr");
    bus_rd('h0000, "R10 prio0 rd");

    // R2 ID 0 hardwired, hart 31 ID lands in second word
    bus_wr('h1000, 32'h1, "R2 id0 set");
    bus_rd('h1000, "R2 id0 rd");
    bus_wr('h1004, 32'h1, "R2 id32 set");
    bus_rd('h1004, "R2 id32 rd");

    // R4 enable of hart 31 in second word, ID 0 bit reads zero
    bus_wr('h2F84, 32'h1, "R4 en31 wr");
    bus_wr('h0080, 32'h1, "R6 prio32 wr");
    chk("R6 irq31 up", 32'(irq[31]), 32'd1);
    bus_rd('h2F84, "R4 en31 rd");
    bus_wr('h2000, 32'hFFFF_FFFF, "R4 en0 wr");
    bus_rd('h2000, "R4 en0 rd");

    // R7 claim by hart 31, then R6 masking while in service
    bus_rd('h21F004, "R7 claim31");
    chk("R7 irq31 down", 32'(irq[31]), 32'd0);
    bus_wr('h1004, 32'h1, "R6 re-raise id32");
    chk("R6 isv masks", 32'(irq[31]), 32'd0);
    bus_wr('h200004, 32'd32, "R8 wrong hart complete");
    chk("R8 ignored", 32'(irq[31]), 32'd0);
    bus_wr('h21F004, 32'd32, "R8 complete31");
    chk("R8 irq31 back", 32'(irq[31]), 32'd1);
    bus_rd('h21F004, "R7 claim31 again");
    bus_wr('h21F004, 32'd32, "R8 complete31 again");

    // R3 zero bits leave flags
    bus_wr('h1000, 32'h6, "R3 set 1,2");
    bus_wr('h1000, 32'h0, "R3 zero wr");
    bus_rd('h1000, "R3 keep");

    // R7 tie on priority picks lower ID, higher priority wins
    bus_wr('h0004, 32'd2, "R7 prio1");
    bus_wr('h0008, 32'd2, "R7 prio2");
    bus_rd('h200004, "R7 tie claim");
    bus_wr('h000C, 32'd5, "R7 prio3");
    bus_wr('h1000, 32'h8, "R7 pend3");
    bus_rd('h200004, "R7 high claim");
    bus_rd('h200004, "R7 next claim");
    bus_rd('h200004, "R7 empty claim");

    // R10 unmapped
    bus_wr('h1008, 32'hFFFF_FFFF, "R10 pend2 wr");
    bus_wr('h3000, 32'hFFFF_FFFF, "R10 page3 wr");
    bus_wr('h3F0000, 32'hFFFF_FFFF, "R10 high wr");
    bus_rd('h1008, "R10 pend2 rd");
    bus_rd('h1000, "R10 pend0 unchanged");
    bus_rd('h1004, "R10 pend1 unchanged");
    bus_rd('h3F0000, "R10 high rd");
    bus_rd('h2000 + 2 * 4, "R10 en word2 rd");

    for (int it = 0; it < 800; it++) begin
      int h  = int'($urandom % NH);
      int w  = int'($urandom % 2);
      int id = 1 + int'($urandom % NH);
      case ($urandom % 6)
        0: bus_wr('h1000 + 4 * w, $urandom & $urandom & $urandom, "R3 rnd pend");
        1: bus_wr('h2000 + h * 128 + 4 * w, $urandom, "R4 rnd en");
        2: bus_wr(4 * id, $urandom % 8, "R5 rnd prio");
        3: bus_rd('h200004 + h * 'h1000, "R7 rnd claim");
        4: bus_wr('h200004 + h * 'h1000,
                  ($urandom % 3 == 0) ? ($urandom % 40) : 32'(id), "R8 rnd complete");
        default: begin
          case ($urandom % 3)
            0: bus_rd('h1000 + 4 * w, "R2 rnd pend rd");
            1: bus_rd('h2000 + h * 128 + 4 * w, "R4 rnd en rd");
            default: bus_rd(4 * id, "R5 rnd prio rd");
          endcase
        end
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule